// File: doc/BRIEF.md
# Sign-Sign LMS Equalizer Adaptation Engine

This block adapts the tap weights of a link equalizer and the data-level reference used by an error sampler, using sign-only arithmetic. For every accepted sample it takes the decided symbol history, as one sign bit per tap, and a one-bit error. The error bit tells whether the received signal sits above the reference the sampler is currently using. Two loops share that single error bit. A level loop moves a reference register up or down by its own step. An equalizer loop moves each tap by its own step in the direction given by the product of the error sign and the sign of the symbol aligned with that tap.

In partial-response mode the level update is qualified on the pair formed by the current and previous decided MSBs. One level register converges to the high level (1+α) and a second register converges to the low level (1−α). Half their difference is output as the post-cursor estimate α. In this mode the level loop and the equalizer loop take turns on successive accepted samples.

All registers saturate at their limits. After every tap update the tap vector is trimmed through its main tap so that the sum of absolute tap values stays within a programmable amplitude budget.

Top module: `sslms_adapt`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets every level register to LEV_INIT (32) and the main tap (index 0) to +127. It sets all other taps to 0 and the phase to the level phase, so `alpha_o` reads 0.
- R2: `s_ready` equals `en`, and a sample is consumed on a clock edge where both `s_valid` and `s_ready` are high. While `en` is low, levels and taps hold their values whatever arrives on the sample inputs.
- R3: In normal mode (`pr_mode`=0) an accepted sample with `s_hist[0]`=1 changes `lev_o` by +`lev_step` when `s_err`=1 and by −`lev_step` when `s_err`=0. With `s_hist[0]`=0, `lev_o` holds. `lev_lo_o` never changes in normal mode.
- R4: Each tap update adds `tap_step` to tap k when `s_hist[k]` equals `s_err`, and subtracts `tap_step` otherwise. Here `s_hist[k]`=1 means the symbol aligned with tap k was decided positive.
- R5: Levels and taps are signed 8-bit values that clamp at +127 and −128 instead of wrapping.
- R6: If a tap update would make the sum of absolute tap values exceed `amp_lim`, the magnitude of the main tap is reduced by the excess, keeping its sign and stopping at 0.
- R7: In partial-response mode, during the level phase, `lev_o` takes the signed step when (`s_hist[0]`,`s_hist[1]`)=(1,1). `lev_lo_o` takes the signed step when the pair is (0,1). Any other pair leaves both levels unchanged.
- R8: `alpha_o` equals (`lev_o` − `lev_lo_o`) shifted right arithmetically by one bit.
- R9: In partial-response mode accepted samples alternate, starting after reset or after leaving the mode: first a level-phase sample, which updates levels only, then a tap-phase sample, which updates taps only. In normal mode one accepted sample updates both loops.
- R10: Level and tap step sizes are independent, and a step of 0 leaves that loop's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Adaptation enable; low freezes all registers |
| pr_mode | input | 1 | 1 selects partial-response mode |
| lev_step | input | 4 | Unsigned level-loop step |
| tap_step | input | 4 | Unsigned equalizer-loop step |
| amp_lim | input | 11 | Budget for the sum of absolute tap values |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (equals `en`) |
| s_hist | input | 4 | Decided sign per tap; bit 0 is the current MSB, bit 1 the previous |
| s_err | input | 1 | Error sign, 1 = signal above reference |
| taps_o | output | 32 | Tap weights, tap k in bits [8k+7:8k] |
| lev_o | output | 8 | Data-level reference, or the high level in partial-response mode |
| lev_lo_o | output | 8 | Low level (partial-response mode) |
| alpha_o | output | 8 | Post-cursor estimate |

## Verification
The level loop is driven with positive and negative decisions under both error signs. This separates a correctly qualified update from one that fires on every sample or steps in the wrong direction. Tap patterns mix agreeing and disagreeing history bits, and a step of zero is applied to one loop while the other moves, so swapped tap indices, a sign inversion or coupled steps all show up. Long runs of one error sign show whether the registers clamp or wrap. Two amplitude budgets separate partial trimming of the main tap from trimming it to zero. In partial-response mode all four MSB pairs are applied across both phases, which distinguishes the (1,1) and (0,1) qualifiers from each other and from the alternation between loops.

// File: rtl/sslms_pkg.sv
package sslms_pkg;
  typedef enum logic {PH_LEVEL = 1'b0, PH_TAP = 1'b1} phase_t;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/sslms_level.sv
module sslms_level #(
  parameter int W      = 8,
  parameter int STEP_W = 4,
  parameter int INIT   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                up,
  input  logic [STEP_W-1:0]   step,
  output logic signed [W-1:0] lev_q
);
  import sslms_pkg::*;
  localparam int HI = 2**(W-1) - 1;
  localparam int LO = -(2**(W-1));

  always_ff @(posedge clk) begin
    if (rst)       lev_q <= W'(INIT);
    else if (fire) lev_q <= W'(clamp_int(int'(lev_q) + (up ? int'(step) : -int'(step)), LO, HI));
  end

  AST_LEV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(lev_q)); // R2
  AST_LEV_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |=> (iabs(int'(lev_q) - int'($past(lev_q))) <= int'($past(step)))); // R3
endmodule

// File: rtl/sslms_taps.sv
module sslms_taps #(
  parameter int NTAP   = 4,
  parameter int W      = 8,
  parameter int STEP_W = 4,
  parameter int LIM_W  = 11,
  parameter int MAIN   = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 err_up,
  input  logic [NTAP-1:0]      dsgn,
  input  logic [STEP_W-1:0]    step,
  input  logic [LIM_W-1:0]     lim,
  output logic [NTAP*W-1:0]    taps_o
);
  import sslms_pkg::*;
  localparam int HI = 2**(W-1) - 1;
  localparam int LO = -(2**(W-1));

  logic signed [W-1:0] w_q    [NTAP];
  logic signed [W-1:0] w_prop [NTAP];
  logic signed [W-1:0] w_next [NTAP];
  int sum_prop, other_sum, cur_sum;

  // proposed sign-sign step, saturated, then trim main tap to the budget
  always_comb begin
    int trim, mag;
    sum_prop = 0;
    for (int k = 0; k < NTAP; k++) begin
      w_prop[k] = W'(clamp_int(int'(w_q[k]) + ((dsgn[k] == err_up) ? int'(step) : -int'(step)), LO, HI));
      sum_prop  = sum_prop + iabs(int'(w_prop[k]));
      w_next[k] = w_prop[k];
    end
    other_sum = sum_prop - iabs(int'(w_prop[MAIN]));
    trim = (sum_prop > int'(lim)) ? sum_prop - int'(lim) : 0;
    mag  = iabs(int'(w_prop[MAIN]));
    mag  = (mag > trim) ? mag - trim : 0;
    w_next[MAIN] = (w_prop[MAIN] < 0) ? W'(-mag) : W'(mag);
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)       w_q[k] <= (k == MAIN) ? W'(HI) : '0;
      else if (fire) w_q[k] <= w_next[k];
    end
    assign taps_o[k*W +: W] = w_q[k];
  end

  always_comb begin
    cur_sum = 0;
    for (int k = 0; k < NTAP; k++) cur_sum = cur_sum + iabs(int'(w_q[k]));
  end

  AST_AMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (fire && other_sum <= int'(lim)) |=> (cur_sum <= int'($past(lim)))); // R6
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(taps_o)); // R2
endmodule

// File: rtl/sslms_adapt.sv
module sslms_adapt #(
  parameter int NTAP     = 4,
  parameter int W        = 8,
  parameter int STEP_W   = 4,
  parameter int LEV_INIT = 32,
  localparam int LIM_W   = W + $clog2(NTAP) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                pr_mode,
  input  logic [STEP_W-1:0]   lev_step,
  input  logic [STEP_W-1:0]   tap_step,
  input  logic [LIM_W-1:0]    amp_lim,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [NTAP-1:0]     s_hist,
  input  logic                s_err,
  output logic [NTAP*W-1:0]   taps_o,
  output logic signed [W-1:0] lev_o,
  output logic signed [W-1:0] lev_lo_o,
  output logic signed [W-1:0] alpha_o
);
  import sslms_pkg::*;

  phase_t phase_q;
  logic   take, fire_hi, fire_lo, fire_tap;

  assign s_ready = en;
  assign take    = s_valid && s_ready;

  // level qualifiers: current MSB alone, or (current, previous) MSB pair
  assign fire_hi  = take && (pr_mode ? (phase_q == PH_LEVEL && s_hist[0] && s_hist[1])
                                     : s_hist[0]);
  assign fire_lo  = take && pr_mode && phase_q == PH_LEVEL && !s_hist[0] && s_hist[1];
  assign fire_tap = take && (!pr_mode || phase_q == PH_TAP);

  always_ff @(posedge clk) begin
    if (rst || !pr_mode) phase_q <= PH_LEVEL;
    else if (take)       phase_q <= (phase_q == PH_LEVEL) ? PH_TAP : PH_LEVEL;
  end

  sslms_level #(.W(W), .STEP_W(STEP_W), .INIT(LEV_INIT)) u_lev_hi (
    .clk(clk), .rst(rst), .fire(fire_hi), .up(s_err), .step(lev_step), .lev_q(lev_o));

  sslms_level #(.W(W), .STEP_W(STEP_W), .INIT(LEV_INIT)) u_lev_lo (
    .clk(clk), .rst(rst), .fire(fire_lo), .up(s_err), .step(lev_step), .lev_q(lev_lo_o));

  sslms_taps #(.NTAP(NTAP), .W(W), .STEP_W(STEP_W), .LIM_W(LIM_W), .MAIN(0)) u_taps (
    .clk(clk), .rst(rst), .fire(fire_tap), .err_up(s_err), .dsgn(s_hist),
    .step(tap_step), .lim(amp_lim), .taps_o(taps_o));

  assign alpha_o = W'((int'(lev_o) - int'(lev_lo_o)) >>> 1);

  AST_PR_ONE_LOOP: assert property (@(posedge clk) disable iff (rst)
    pr_mode |-> !((fire_hi || fire_lo) && fire_tap)); // R9
  AST_LO_NORMAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pr_mode && !$past(pr_mode)) |-> $stable(lev_lo_o)); // R3
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (pr_mode && take) |=> (!pr_mode || phase_q != $past(phase_q) || $past(rst))); // R9
endmodule

// File: tb/sslms_adapt_tb.sv
module sslms_adapt_tb_top;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, pr_mode = 1'b0;
  logic [3:0] lev_step = '0, tap_step = '0;
  logic [10:0] amp_lim = 11'd1000;
  logic s_valid = 1'b0, s_ready, s_err = 1'b0;
  logic [3:0] s_hist = '0;
  logic [31:0] taps_o;
  logic signed [7:0] lev_o, lev_lo_o, alpha_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sslms_adapt dut_i (.clk(clk), .rst(rst), .en(en), .pr_mode(pr_mode), .lev_step(lev_step),
    .tap_step(tap_step), .amp_lim(amp_lim), .s_valid(s_valid), .s_ready(s_ready),
    .s_hist(s_hist), .s_err(s_err), .taps_o(taps_o), .lev_o(lev_o), .lev_lo_o(lev_lo_o),
    .alpha_o(alpha_o));

  function automatic int tap(input int k);
    return int'($signed(taps_o[k*W +: W]));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_taps(input string req, input int t0, input int t1, input int t2, input int t3);
    check(req, tap(0), t0); check(req, tap(1), t1);
    check(req, tap(2), t2); check(req, tap(3), t3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; s_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic [3:0] h, input logic e);
    @(negedge clk); s_valid = 1'b1; s_hist = h; s_err = e;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic t_reset();
    en = 1'b0; do_reset();
    check("R1 taps", 0, 0);
    check_taps("R1", 127, 0, 0, 0);
    check("R1 lev", int'(lev_o), 32);
    check("R1 lev_lo", int'(lev_lo_o), 32);
    check("R1 alpha", int'(alpha_o), 0);
    check("R2 ready low", int'(s_ready), 0);
  endtask

  task automatic t_level();
    do_reset(); en = 1'b1; pr_mode = 1'b0; lev_step = 4'd2; tap_step = 4'd0; amp_lim = 11'd1000;
    send(4'b0001, 1'b1); check("R3 up", int'(lev_o), 34);
    check_taps("R10 zero tap step", 127, 0, 0, 0);
    send(4'b0001, 1'b0); check("R3 down", int'(lev_o), 32);
    send(4'b0000, 1'b1); check("R3 negative hold", int'(lev_o), 32);
    check("R3 lev_lo normal", int'(lev_lo_o), 32);
  endtask

  task automatic t_taps();
    do_reset(); en = 1'b1; lev_step = 4'd0; tap_step = 4'd1; amp_lim = 11'd1000;
    send(4'b1011, 1'b1); check_taps("R4 mix", 127, 1, -1, 1);
    check("R10 zero lev step", int'(lev_o), 32);
    send(4'b0100, 1'b1); check_taps("R4 second", 126, 0, 0, 0);
  endtask

  task automatic t_sat();
    do_reset(); en = 1'b1; lev_step = 4'd15; tap_step = 4'd0;
    for (int i = 0; i < 7; i++) send(4'b0001, 1'b1);
    check("R5 high clamp", int'(lev_o), 127);
    for (int i = 0; i < 17; i++) send(4'b0001, 1'b0);
    check("R5 low clamp", int'(lev_o), -128);
  endtask

  task automatic t_freeze();
    do_reset(); en = 1'b0; lev_step = 4'd5; tap_step = 4'd5;
    send(4'b0001, 1'b1); send(4'b1111, 1'b0); send(4'b0011, 1'b1);
    check("R2 ready", int'(s_ready), 0);
    check("R2 lev frozen", int'(lev_o), 32);
    check_taps("R2 taps frozen", 127, 0, 0, 0);
    @(negedge clk); en = 1'b1; #1;
    check("R2 ready high", int'(s_ready), 1);
  endtask

  task automatic t_amp();
    do_reset(); en = 1'b1; lev_step = 4'd0; tap_step = 4'd3; amp_lim = 11'd127;
    send(4'b0010, 1'b1); check_taps("R6 partial trim", 118, 3, -3, -3);
    amp_lim = 11'd10;
    send(4'b0010, 1'b1); check_taps("R6 trim to zero", 0, 6, -6, -6);
  endtask

  task automatic t_pr();
    do_reset(); en = 1'b1; pr_mode = 1'b1; lev_step = 4'd4; tap_step = 4'd1; amp_lim = 11'd1000;
    send(4'b0011, 1'b1);
    check("R7 hi pair", int'(lev_o), 36);
    check_taps("R9 level phase taps hold", 127, 0, 0, 0);
    send(4'b0011, 1'b1);
    check("R9 tap phase lev hold", int'(lev_o), 36);
    check_taps("R9 tap phase", 127, 1, -1, -1);
    send(4'b0010, 1'b0);
    check("R7 lo pair", int'(lev_lo_o), 28);
    check("R7 hi unchanged", int'(lev_o), 36);
    check("R8 alpha", int'(alpha_o), 4);
    send(4'b0000, 1'b0); check("R9 tap phase 2", tap(1), 2);
    send(4'b0001, 1'b1);
    check("R7 pair 10 hi", int'(lev_o), 36);
    check("R7 pair 10 lo", int'(lev_lo_o), 28);
    @(negedge clk); pr_mode = 1'b0;
    send(4'b0001, 1'b1);
    check("R9 normal lev", int'(lev_o), 40);
    check("R9 normal tap", tap(1), 1);
    check("R8 alpha normal", int'(alpha_o), 6);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset(); t_level(); t_taps(); t_sat(); t_freeze(); t_amp(); t_pr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule